// File: doc/BRIEF.md
# Gigabit UDP Frame Receiver and Checker

This block sits behind a gigabit byte-wide receive interface. It takes one byte per clock while a receive-valid input is high. It finds the preamble and the start delimiter, then walks the Ethernet, IPv4 and UDP headers byte by byte. It captures the MAC addresses, the IP addresses, the ports and the UDP checksum field, and it derives the UDP payload length from the IP total length.

Payload bytes are forwarded one per clock with a valid strobe, one clock after they arrive. Bytes that only pad the frame up to the minimum size are never forwarded. While the frame streams in, the block checks the IPv4 header checksum and the Ethernet CRC-32. When receive-valid falls, a one-clock done pulse reports four things: whether the header was accepted, whether the IP checksum was good, whether the CRC was good, and whether the frame was cut short.

IP options, fragmentation, VLAN tags and UDP checksum checking are not handled.

Top module: `udp_gmii_rx`

## Requirements
- R1: After reset, every output is zero.
- R2: A frame starts only when one or more 0x55 bytes are followed by 0xD5. Any other byte inside the preamble, or a first byte other than 0x55, makes the block ignore input until receive-valid drops. Such a frame produces no payload and no done pulse.
- R3: The fields are sent most significant byte first. They sit at these byte offsets after the delimiter:
  - destination MAC at 0–5
  - source MAC at 6–11
  - source IP at 26–29
  - destination IP at 30–33
  - source port at 34–35
  - destination port at 36–37
  - UDP checksum at 40–41

  Each field appears on its output once its bytes have arrived. `pay_len_o` equals the IP total length (offsets 16–17) minus 28.
- R4: The header is accepted only if all of these hold: the type at offsets 12–13 is 0x0800, the byte at 14 is 0x45, the protocol byte at 23 is 0x11, the total length is at least 28, and the UDP length at 38–39 equals the total length minus 20. `hdr_ok_o` reports this.
- R5: `ip_ok_o` is 1 when the header is accepted and the ten big-endian words at offsets 14–33, summed with end-around carry, give 0xFFFF.
- R6: A CRC-32 register (reflected polynomial 0xEDB88320) is preset to all ones at the delimiter. It runs over every byte after the delimiter, including the frame check sequence, which is sent least significant byte first. `crc_ok_o` is 1 when the final register equals 0xDEBB20E3.
- R7: In an accepted frame, bytes at offsets 42 up to 42 + payload length − 1 appear on `pay_data_o` with `pay_valid_o` high, exactly one clock after the byte is sampled. No other byte raises `pay_valid_o`.
- R8: Zero fill bytes, which follow the payload when 28 + payload is below 46, are never forwarded.
- R9: `done_o` is high for exactly one clock, in the clock after the first sampled low receive-valid that follows a delimiter. The four flags are valid with it and hold until the next done.
- R10: The required byte count after the delimiter is max(64, total length + 18) for an accepted header, and 64 otherwise. A frame that ends with fewer bytes than this sets `trunc_o` and clears `hdr_ok_o`, `ip_ok_o` and `crc_ok_o`.
- R11: While receive-valid is low, `rx_data_i` has no effect: no frame starts, no payload is forwarded and no done is raised by those bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_dv_i | input | 1 | Receive-valid qualifier |
| rx_data_i | input | 8 | Received byte |
| dst_mac_o | output | 48 | Captured destination MAC |
| src_mac_o | output | 48 | Captured source MAC |
| src_ip_o | output | 32 | Captured source IP |
| dst_ip_o | output | 32 | Captured destination IP |
| src_port_o | output | 16 | Captured source port |
| dst_port_o | output | 16 | Captured destination port |
| pay_len_o | output | 16 | UDP payload length from IP total length |
| udp_csum_o | output | 16 | Captured UDP checksum field, not verified |
| pay_valid_o | output | 1 | Payload byte strobe |
| pay_data_o | output | 8 | Payload byte |
| done_o | output | 1 | End-of-frame pulse |
| hdr_ok_o | output | 1 | Header accepted |
| ip_ok_o | output | 1 | IP header checksum good |
| crc_ok_o | output | 1 | Frame CRC good |
| trunc_o | output | 1 | Frame ended early |

## Verification
The assertions assume that receive-valid stays high without a gap from the first preamble byte to the last check-sequence byte. They also assume that each frame is followed by at least one low cycle before the next preamble. Under those two assumptions, checksum bytes arrive in even/odd pairs, and every entry to the receiving state comes straight from a delimiter byte. The stimulus keeps within these assumptions: every frame is driven as one contiguous burst, and two or more idle cycles follow it. During the idle cycles the data lines carry 0x55 and 0xD5, to show that bytes without receive-valid are ignored.

// File: rtl/udp_rx_pkg.sv
package udp_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int MAC_W  = 48;
  localparam int IP_W   = 32;
  localparam int PORT_W = 16;
  localparam int LEN_W  = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_RX, ST_DROP} rx_st_e;

  localparam logic [7:0]  PRE_BYTE    = 8'h55;
  localparam logic [7:0]  SFD_BYTE    = 8'hD5;
  localparam logic [15:0] ETYPE_IP    = 16'h0800;
  localparam logic [7:0]  VER_IHL     = 8'h45;
  localparam logic [7:0]  PROTO_UDP   = 8'h11;
  localparam logic [31:0] CRC_POLY_R  = 32'hEDB88320;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

  // byte offsets counted from the first byte after the delimiter
  localparam int OFS_DMAC  = 0;
  localparam int OFS_SMAC  = 6;
  localparam int OFS_TYPE  = 12;
  localparam int OFS_IP    = 14;
  localparam int OFS_TLEN  = 16;
  localparam int OFS_PROTO = 23;
  localparam int OFS_SIP   = 26;
  localparam int OFS_DIP   = 30;
  localparam int OFS_SPORT = 34;
  localparam int OFS_DPORT = 36;
  localparam int OFS_ULEN  = 38;
  localparam int OFS_UCS   = 40;
  localparam int OFS_PAY   = 42;

  localparam int IP_HDR_BYTES  = 20;
  localparam int UDP_HDR_BYTES = 8;
  localparam int MIN_DATA      = 46;
  localparam int FCS_BYTES     = 4;

  function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_R;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/udp_rx_crc32.sv
module udp_rx_crc32
  import udp_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              en_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              good_o
);
  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (init_i) crc_q <= '1;
    else if (en_i)   crc_q <= crc_step(crc_q, byte_i);
  end

  // residue check: register has run over payload and FCS alike
  assign good_o = (crc_q == CRC_RESIDUE);

  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_i && !en_i |=> $stable(good_o));
endmodule

// File: rtl/udp_rx_ipsum.sv
module udp_rx_ipsum
  import udp_rx_pkg::*;
#(
  parameter int SUM_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              odd_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              good_o
);
  logic [BYTE_W-1:0] hi_q;
  logic [SUM_W-1:0]  sum_q;
  logic [16:0]       fold1;
  logic [15:0]       fold2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      sum_q <= '0;
    end else if (clr_i) begin
      hi_q  <= '0;
      sum_q <= '0;
    end else if (en_i) begin
      if (!odd_i) hi_q <= byte_i;
      else        sum_q <= sum_q + SUM_W'({hi_q, byte_i});
    end
  end

  always_comb begin
    fold1 = {1'b0, sum_q[15:0]} + 17'(sum_q[SUM_W-1:16]);
    fold2 = fold1[15:0] + 16'(fold1[16]);
  end

  assign good_o = (fold2 == 16'hFFFF);

  // low byte of a word always directly follows its high byte
  a_r5_word_pairs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && odd_i |-> $past(en_i && !odd_i));
endmodule

// File: rtl/udp_gmii_rx.sv
module udp_gmii_rx
  import udp_rx_pkg::*;
#(
  parameter int CNT_W = 17,
  parameter int SUM_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_dv_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic [MAC_W-1:0]  dst_mac_o,
  output logic [MAC_W-1:0]  src_mac_o,
  output logic [IP_W-1:0]   src_ip_o,
  output logic [IP_W-1:0]   dst_ip_o,
  output logic [PORT_W-1:0] src_port_o,
  output logic [PORT_W-1:0] dst_port_o,
  output logic [LEN_W-1:0]  pay_len_o,
  output logic [LEN_W-1:0]  udp_csum_o,
  output logic              pay_valid_o,
  output logic [BYTE_W-1:0] pay_data_o,
  output logic              done_o,
  output logic              hdr_ok_o,
  output logic              ip_ok_o,
  output logic              crc_ok_o,
  output logic              trunc_o
);
  localparam int               HDR_ALL   = IP_HDR_BYTES + UDP_HDR_BYTES;
  localparam logic [CNT_W-1:0] MIN_FRAME = CNT_W'(OFS_IP + MIN_DATA + FCS_BYTES);
  localparam logic [CNT_W-1:0] PAY_OFS_C = CNT_W'(OFS_PAY);
  localparam logic [CNT_W-1:0] TLEN_LO   = CNT_W'(OFS_TLEN + 1);

  rx_st_e            st_q;
  logic [CNT_W-1:0]  idx_q, idx_nxt, pay_end, need_len, tlen_need;
  logic              acc_q, acc_fail, in_rx, sof, fin, short_frm;
  logic [LEN_W-1:0]  tlen_q;
  logic [BYTE_W-1:0] lst_q;
  logic              ip_good, crc_good;

  function automatic logic hit(logic [CNT_W-1:0] i, int lo, int n);
    return (i >= CNT_W'(lo)) && (i < CNT_W'(lo + n));
  endfunction

  assign in_rx   = (st_q == ST_RX) && rx_dv_i;
  assign sof     = (st_q == ST_PRE) && rx_dv_i && (rx_data_i == SFD_BYTE);
  assign fin     = (st_q == ST_RX) && !rx_dv_i;
  assign idx_nxt = (&idx_q) ? idx_q : idx_q + 1'b1;

  // last forwarded offset + 1 = 14 + IP total length
  assign pay_end   = CNT_W'(tlen_q) + CNT_W'(OFS_IP);
  assign tlen_need = CNT_W'(tlen_q) + CNT_W'(OFS_IP + FCS_BYTES);
  assign need_len  = (acc_q && tlen_need > MIN_FRAME) ? tlen_need : MIN_FRAME;
  assign short_frm = idx_q < need_len;

  always_comb begin
    acc_fail = 1'b0;
    if (in_rx) begin
      unique case (idx_q)
        CNT_W'(OFS_TYPE + 1): acc_fail = {lst_q, rx_data_i} != ETYPE_IP;
        CNT_W'(OFS_IP):       acc_fail = rx_data_i != VER_IHL;
        CNT_W'(OFS_PROTO):    acc_fail = rx_data_i != PROTO_UDP;
        CNT_W'(OFS_ULEN + 1): acc_fail = (tlen_q < LEN_W'(HDR_ALL)) ||
                                ({lst_q, rx_data_i} != tlen_q - LEN_W'(IP_HDR_BYTES));
        default:              acc_fail = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      acc_q  <= 1'b0;
      tlen_q <= '0;
      lst_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (rx_dv_i) st_q <= (rx_data_i == PRE_BYTE) ? ST_PRE : ST_DROP;
        ST_PRE: begin
          if (!rx_dv_i) st_q <= ST_IDLE;
          else if (rx_data_i == SFD_BYTE) begin
            st_q  <= ST_RX;
            idx_q <= '0;
            acc_q <= 1'b1;
          end else if (rx_data_i != PRE_BYTE) st_q <= ST_DROP;
        end
        ST_RX: begin
          if (!rx_dv_i) st_q <= ST_IDLE;
          else begin
            idx_q <= idx_nxt;
            lst_q <= rx_data_i;
            if (acc_fail) acc_q <= 1'b0;
            if (idx_q == TLEN_LO) tlen_q <= {lst_q, rx_data_i};
          end
        end
        default: if (!rx_dv_i) st_q <= ST_IDLE;
      endcase
    end
  end

  // header field capture, most significant byte first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_mac_o  <= '0;
      src_mac_o  <= '0;
      src_ip_o   <= '0;
      dst_ip_o   <= '0;
      src_port_o <= '0;
      dst_port_o <= '0;
      udp_csum_o <= '0;
    end else if (in_rx) begin
      if (hit(idx_q, OFS_DMAC, 6))  dst_mac_o  <= {dst_mac_o[MAC_W-BYTE_W-1:0], rx_data_i};
      if (hit(idx_q, OFS_SMAC, 6))  src_mac_o  <= {src_mac_o[MAC_W-BYTE_W-1:0], rx_data_i};
      if (hit(idx_q, OFS_SIP, 4))   src_ip_o   <= {src_ip_o[IP_W-BYTE_W-1:0], rx_data_i};
      if (hit(idx_q, OFS_DIP, 4))   dst_ip_o   <= {dst_ip_o[IP_W-BYTE_W-1:0], rx_data_i};
      if (hit(idx_q, OFS_SPORT, 2)) src_port_o <= {src_port_o[PORT_W-BYTE_W-1:0], rx_data_i};
      if (hit(idx_q, OFS_DPORT, 2)) dst_port_o <= {dst_port_o[PORT_W-BYTE_W-1:0], rx_data_i};
      if (hit(idx_q, OFS_UCS, 2))   udp_csum_o <= {udp_csum_o[LEN_W-BYTE_W-1:0], rx_data_i};
    end
  end

  assign pay_len_o = (tlen_q >= LEN_W'(HDR_ALL)) ? tlen_q - LEN_W'(HDR_ALL) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pay_valid_o <= 1'b0;
      pay_data_o  <= '0;
    end else begin
      pay_valid_o <= in_rx && acc_q && (idx_q >= PAY_OFS_C) && (idx_q < pay_end);
      if (in_rx) pay_data_o <= rx_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      hdr_ok_o <= 1'b0;
      ip_ok_o  <= 1'b0;
      crc_ok_o <= 1'b0;
      trunc_o  <= 1'b0;
    end else begin
      done_o <= fin;
      if (fin) begin
        trunc_o  <= short_frm;
        hdr_ok_o <= acc_q && !short_frm;
        ip_ok_o  <= acc_q && ip_good && !short_frm;
        crc_ok_o <= crc_good && !short_frm;
      end
    end
  end

  udp_rx_ipsum #(.SUM_W(SUM_W)) u_ipsum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sof),
    .en_i   (in_rx && hit(idx_q, OFS_IP, IP_HDR_BYTES)),
    .odd_i  (idx_q[0]),
    .byte_i (rx_data_i),
    .good_o (ip_good)
  );

  udp_rx_crc32 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (sof),
    .en_i   (in_rx),
    .byte_i (rx_data_i),
    .good_o (crc_good)
  );

  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_done_after_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !$past(rx_dv_i));
  a_r7_pay_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_valid_o |-> $past(rx_dv_i) && (pay_data_o == $past(rx_data_i)));
  a_r7_pay_needs_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_valid_o |-> $past(acc_q));
  a_r2_rx_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == ST_RX) |-> ($past(st_q) == ST_PRE) && ($past(rx_data_i) == SFD_BYTE));
  a_r10_trunc_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && trunc_o |-> !hdr_ok_o && !ip_ok_o && !crc_ok_o);
endmodule

// File: tb/sim_udp_gmii_rx.sv
`timescale 1ns/1ps
module sim_udp_gmii_rx;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_dv = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic [47:0] dst_mac_o, src_mac_o;
  logic [31:0] src_ip_o, dst_ip_o;
  logic [15:0] src_port_o, dst_port_o, pay_len_o, udp_csum_o;
  logic        pay_valid_o, done_o, hdr_ok_o, ip_ok_o, crc_ok_o, trunc_o;
  logic [7:0]  pay_data_o;

  int    total = 0;
  int    bad = 0;
  bit    fin = 0;
  bit    exp_v = 0, exp_done = 0;
  logic [7:0] exp_d = 8'h00;
  logic [3:0] exp_fl = 4'h0;
  string exp_rq = "R1";
  string ctx = "reset";

  always #10 clk = ~clk;

  udp_gmii_rx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .rx_dv_i(rx_dv), .rx_data_i(rx_data),
    .dst_mac_o(dst_mac_o), .src_mac_o(src_mac_o), .src_ip_o(src_ip_o), .dst_ip_o(dst_ip_o),
    .src_port_o(src_port_o), .dst_port_o(dst_port_o), .pay_len_o(pay_len_o),
    .udp_csum_o(udp_csum_o), .pay_valid_o(pay_valid_o), .pay_data_o(pay_data_o),
    .done_o(done_o), .hdr_ok_o(hdr_ok_o), .ip_ok_o(ip_ok_o), .crc_ok_o(crc_ok_o),
    .trunc_o(trunc_o)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s [%s]: actual=%0h expected=%0h", rq, what, ctx, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_upd(logic [31:0] c, logic [7:0] d);
    for (int b = 0; b < 8; b++) c = (c[0] ^ d[b]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    return c;
  endfunction

  // compare outputs of the previous edge, then drive the next byte and its expectation
  task automatic step(input logic dv, input logic [7:0] d, input bit nv, input logic [7:0] nd,
                      input bit ndone, input logic [3:0] nfl, input string rq);
    @(negedge clk);
    chk(pay_valid_o == exp_v, exp_rq, "pay_valid", pay_valid_o, exp_v);
    if (exp_v) chk(pay_data_o == exp_d, "R7", "pay_data", pay_data_o, exp_d);
    chk(done_o == exp_done, (exp_rq == "R2" || exp_rq == "R11") ? exp_rq : "R9", "done",
        done_o, exp_done);
    if (exp_done) begin
      chk(hdr_ok_o == exp_fl[3], "R4", "hdr_ok", hdr_ok_o, exp_fl[3]);
      chk(ip_ok_o == exp_fl[2], "R5", "ip_ok", ip_ok_o, exp_fl[2]);
      chk(crc_ok_o == exp_fl[1], "R6", "crc_ok", crc_ok_o, exp_fl[1]);
      chk(trunc_o == exp_fl[0], "R10", "trunc", trunc_o, exp_fl[0]);
    end
    rx_dv = dv; rx_data = d;
    exp_v = nv; exp_d = nd; exp_done = ndone; exp_fl = nfl; exp_rq = rq;
  endtask

  // mode: 0 good, 1 bad FCS, 2 bad IP checksum, 3 bad type, 4 bad protocol,
  //       5 bad UDP length, 6 bad delimiter; cut<0 sends the whole frame
  task automatic send_frame(input int plen, input int mode, input int cut, input string name);
    logic [7:0]  fr[$];
    logic [47:0] dmac, smac;
    logic [31:0] sip, dip, s, c;
    logic [15:0] sp, dpt, cs, ulen;
    int tot, n, need;
    bit acc, tr, v;
    logic [3:0] fl;
    string rq;
    ctx = name;
    tot  = 28 + plen;
    dmac = 48'h02_11_22_33_44_00 | 48'(plen);
    smac = 48'h0A_BC_DE_F0_12_34;
    sip  = 32'hC0A8_0103 + 32'(plen);
    dip  = 32'h0A00_00FE;
    sp   = 16'd4321 + 16'(mode);
    dpt  = 16'd9000;
    fr = {};
    for (int i = 0; i < 6; i++) fr.push_back(dmac[47-8*i -: 8]);
    for (int i = 0; i < 6; i++) fr.push_back(smac[47-8*i -: 8]);
    fr.push_back(8'h08); fr.push_back(mode == 3 ? 8'h06 : 8'h00);
    fr.push_back(8'h45); fr.push_back(8'h00);
    fr.push_back(8'(tot >> 8)); fr.push_back(8'(tot));
    fr.push_back(8'h12); fr.push_back(8'(plen));
    fr.push_back(8'h40); fr.push_back(8'h00);
    fr.push_back(8'h40); fr.push_back(mode == 4 ? 8'h06 : 8'h11);
    fr.push_back(8'h00); fr.push_back(8'h00);
    for (int i = 0; i < 4; i++) fr.push_back(sip[31-8*i -: 8]);
    for (int i = 0; i < 4; i++) fr.push_back(dip[31-8*i -: 8]);
    s = 0;
    for (int i = 14; i < 34; i += 2) s += {16'h0, fr[i], fr[i+1]};
    while (s[31:16] != 0) s = {16'h0, s[15:0]} + {16'h0, s[31:16]};
    cs = ~s[15:0];
    if (mode == 2) cs ^= 16'h0100;
    fr[24] = cs[15:8]; fr[25] = cs[7:0];
    ulen = 16'(8 + plen + (mode == 5 ? 1 : 0));
    fr.push_back(sp[15:8]);  fr.push_back(sp[7:0]);
    fr.push_back(dpt[15:8]); fr.push_back(dpt[7:0]);
    fr.push_back(ulen[15:8]); fr.push_back(ulen[7:0]);
    fr.push_back(8'hBE); fr.push_back(8'hEF);
    for (int i = 0; i < plen; i++) fr.push_back(8'(i * 13 + 5));
    while (fr.size() < 60) fr.push_back(8'h00);
    c = 32'hFFFF_FFFF;
    foreach (fr[i]) c = crc_upd(c, fr[i]);
    c = ~c;
    fr.push_back(c[7:0]); fr.push_back(c[15:8]); fr.push_back(c[23:16]); fr.push_back(c[31:24]);
    if (mode == 1) fr[fr.size()-1] ^= 8'h01;

    acc  = !(mode inside {3, 4, 5});
    n    = (cut < 0) ? fr.size() : cut;
    need = acc ? ((tot + 18 > 64) ? tot + 18 : 64) : 64;
    tr   = n < need;
    fl   = {acc && !tr, acc && mode != 2 && !tr, mode != 1 && !tr, tr};

    for (int i = 0; i < 7; i++) step(1'b1, 8'h55, 1'b0, 8'h00, 1'b0, 4'h0, "R2");
    step(1'b1, mode == 6 ? 8'h57 : 8'hD5, 1'b0, 8'h00, 1'b0, 4'h0, "R2");
    for (int k = 0; k < n; k++) begin
      v  = (mode != 6) && acc && (k >= 42) && (k < 42 + plen);
      rq = (mode == 6) ? "R2" : ((k >= 42 + plen && k < 60) ? "R8" : "R7");
      step(1'b1, fr[k], v, fr[k], 1'b0, 4'h0, rq);
    end
    step(1'b0, 8'h55, 1'b0, 8'h00, mode != 6, fl, "R9");
    step(1'b0, 8'hD5, 1'b0, 8'h00, 1'b0, 4'h0, "R11");
    if (mode == 0 && cut < 0) begin
      chk(dst_mac_o == dmac, "R3", "dst_mac", dst_mac_o, dmac);
      chk(src_mac_o == smac, "R3", "src_mac", src_mac_o, smac);
      chk(src_ip_o == sip, "R3", "src_ip", src_ip_o, sip);
      chk(dst_ip_o == dip, "R3", "dst_ip", dst_ip_o, dip);
      chk(src_port_o == sp, "R3", "src_port", src_port_o, sp);
      chk(dst_port_o == dpt, "R3", "dst_port", dst_port_o, dpt);
      chk(udp_csum_o == 16'hBEEF, "R3", "udp_csum", udp_csum_o, 16'hBEEF);
      chk(pay_len_o == 16'(plen), "R3", "pay_len", pay_len_o, plen);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    ctx = "R1 after reset";
    chk(done_o == 0 && pay_valid_o == 0, "R1", "done/pay_valid", {done_o, pay_valid_o}, 0);
    chk({hdr_ok_o, ip_ok_o, crc_ok_o, trunc_o} == 0, "R1", "flags",
        {hdr_ok_o, ip_ok_o, crc_ok_o, trunc_o}, 0);
    chk(dst_mac_o == 0 && src_ip_o == 0 && pay_len_o == 0, "R1", "fields",
        dst_mac_o ^ 48'(src_ip_o) ^ 48'(pay_len_o), 0);
    // R11: preamble-like bytes without receive-valid
    ctx = "R11 idle junk";
    for (int i = 0; i < 8; i++) step(1'b0, i[0] ? 8'hD5 : 8'h55, 1'b0, 8'h00, 1'b0, 4'h0, "R11");
    send_frame(10, 0, -1, "R8 padded 10 byte payload");
    send_frame(18, 0, -1, "R7 exactly minimum data");
    send_frame(40, 0, -1, "R7 long payload");
    send_frame(0, 0, -1, "R8 empty payload");
    send_frame(1, 0, -1, "R8 one byte payload");
    send_frame(12, 1, -1, "R6 corrupted FCS");
    send_frame(12, 2, -1, "R5 corrupted IP checksum");
    send_frame(12, 3, -1, "R4 wrong type");
    send_frame(12, 4, -1, "R4 wrong protocol");
    send_frame(12, 5, -1, "R4 UDP length mismatch");
    send_frame(12, 6, -1, "R2 bad delimiter");
    send_frame(30, 0, 50, "R10 cut in payload");
    send_frame(30, 0, 74, "R10 cut in FCS");
    send_frame(5, 0, 20, "R10 cut in header");
    send_frame(20, 0, -1, "R9 good after truncation");
    step(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'h0, "R11");
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule